// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block commits the outcome of one floating-point operation to the processor's floating-point status word and program-counter pair. The execution unit reports a five-bit IEEE exception set with a strobe. The block combines it with the trap-enable field of the current status word and decides whether the operation must trap. Then it writes back a new status word, a new PC and next-PC, and raises a trap request when one is needed.

On the trap path the enabled flags are reduced to a single flag by a fixed priority. That flag is written to the current-exception field and the trap-type field is marked as an IEEE exception. The accrued field and both PCs are left untouched. On the non-trap path the raw flag set overwrites the current-exception field and is ORed into the accrued field. The PC pair then steps past the instruction. A small state machine records the outcome of each strobe as IDLE (no strobe), RETIRE (non-trap update) or TRAP (trap update). The transition is made on every clock: a strobe with an enabled flag goes to TRAP, a strobe without one goes to RETIRE, and no strobe goes to IDLE. All outputs are registered and appear one cycle after the strobe.

Top module: `fpx_status_recorder`

## Requirements
- R1: While reset is asserted and after it is released, `upd_vld` and `trap_req` are 0 and `stat_out`, `pc_out` and `npc_out` are 0 until the first strobe.
- R2: A strobed operation traps exactly when the AND of `flags` with the enable field `stat_in[27:23]` is nonzero.
- R3: Flag bits are invalid=4, overflow=3, underflow=2, divide-by-zero=1 and inexact=0. On a trap, `stat_out[4:0]` holds only the highest-numbered bit of (`flags` AND enable field).
- R4: Without a trap, `stat_out[4:0]` equals `flags` unchanged, including flags that are not enabled.
- R5: Without a trap, `stat_out[9:5]` is `stat_in[9:5]` OR `flags`. On a trap, `stat_out[9:5]` equals `stat_in[9:5]`.
- R6: On a trap, `stat_out[16:14]` is 3'b001. Without a trap, it equals `stat_in[16:14]`.
- R7: On a trap, `pc_out` equals `pc_in` and `npc_out` equals `npc_in`.
- R8: Without a trap, `pc_out` equals `npc_in` and `npc_out` equals `npc_in + 4`, wrapping modulo 2^PC_W.
- R9: A strobed operation with `flags` = 0 never traps. It clears `stat_out[4:0]`, leaves the accrued field unchanged and advances the PCs.
- R10: Results appear one clock after `flag_vld`, with `upd_vld` high for that cycle. `trap_req` is high in that same cycle exactly for a trapping operation. A cycle without a strobe gives `upd_vld` = `trap_req` = 0 on the next cycle, and the other outputs hold.
- R11: Every status bit outside fields 4:0, 9:5 and 16:14 passes from `stat_in` to `stat_out` unchanged, including the enable field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_vld | input | 1 | Strobe: an operation has completed and `flags` is valid |
| flags | input | 5 | IEEE exception set of the operation |
| stat_in | input | STAT_W | Status word before the update |
| pc_in | input | PC_W | PC of the operation |
| npc_in | input | PC_W | Next-PC of the operation |
| stat_out | output | STAT_W | Updated status word |
| pc_out | output | PC_W | Updated PC |
| npc_out | output | PC_W | Updated next-PC |
| upd_vld | output | 1 | Outputs carry a new update this cycle |
| trap_req | output | 1 | The update is a trap |

## Verification
The bench goes after several corner cases. One is several enabled flags at once, where a design with an inverted priority would report inexact instead of invalid. Another is flags that are raised but not enabled, where a design that masks the non-trap path would lose them from the current and accrued fields. It also checks an accrued field that already holds bits during a trap, which a design that ORs on both paths would corrupt. The remaining cases are a zero flag set, a next-PC at the top of the address range (the step must wrap), and idle cycles where a stale update or trap pulse would show.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int FLAG_W   = 5;
    localparam int CUR_LSB  = 0;
    localparam int ACC_LSB  = 5;
    localparam int ENA_LSB  = 23;
    localparam int TT_LSB   = 14;
    localparam int TT_W     = 3;
    localparam logic [TT_W-1:0] TT_IEEE = 3'd1;

    // flag positions; higher index wins on a trap
    localparam int FL_INV = 4;
    localparam int FL_OVF = 3;
    localparam int FL_UNF = 2;
    localparam int FL_DVZ = 1;
    localparam int FL_NXT = 0;

    localparam int STAT_MIN_W = ENA_LSB + FLAG_W;

    typedef logic [FLAG_W-1:0] flag_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RETIRE = 2'd1,
        S_TRAP   = 2'd2
    } rec_state_e;
endpackage

// File: rtl/fpx_trap_eval.sv
module fpx_trap_eval
    import fpx_pkg::*;
(
    input  flag_t flags,
    input  flag_t enables,
    output logic  take_trap,
    output flag_t trap_flag
);
    flag_t              hit;
    logic [FLAG_W:0]    above;

    assign hit       = flags & enables;
    assign take_trap = |hit;
    assign above[FLAG_W] = 1'b0;

    // ripple from the top bit down: keep a bit only if nothing above it hit
    for (genvar i = FLAG_W - 1; i >= 0; i--) begin : g_prio
        assign trap_flag[i] = hit[i] & ~above[i+1];
        assign above[i]     = above[i+1] | hit[i];
    end
endmodule

// File: rtl/fpx_status_merge.sv
module fpx_status_merge
    import fpx_pkg::*;
#(
    parameter int STAT_W = 64
) (
    input  logic [STAT_W-1:0] stat,
    input  flag_t             flags,
    input  flag_t             trap_flag,
    input  logic              take_trap,
    output logic [STAT_W-1:0] stat_nxt
);
    localparam int CUR_MSB = CUR_LSB + FLAG_W - 1;

    flag_t acc_old;
    assign acc_old = stat[ACC_LSB +: FLAG_W];

    always_comb begin
        stat_nxt = stat;
        if (take_trap) begin
            stat_nxt[CUR_LSB +: FLAG_W] = trap_flag;
            stat_nxt[TT_LSB +: TT_W]    = TT_IEEE;
        end else begin
            stat_nxt[CUR_LSB +: FLAG_W] = flags;
            stat_nxt[ACC_LSB +: FLAG_W] = acc_old | flags;
        end
    end

    initial begin
        if (STAT_W < STAT_MIN_W) $error("STAT_W too small for enable field");
        if (CUR_MSB >= ACC_LSB) $error("field overlap");
    end
endmodule

// File: rtl/fpx_pc_step.sv
module fpx_pc_step #(
    parameter int PC_W    = 64,
    parameter int PC_STEP = 4
) (
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] npc,
    input  logic            take_trap,
    output logic [PC_W-1:0] pc_nxt,
    output logic [PC_W-1:0] npc_nxt
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    always_comb begin
        if (take_trap) begin
            pc_nxt  = pc;
            npc_nxt = npc;
        end else begin
            pc_nxt  = npc;
            npc_nxt = npc + STEP;
        end
    end
endmodule

// File: rtl/fpx_status_recorder.sv
module fpx_status_recorder
    import fpx_pkg::*;
#(
    parameter int STAT_W  = 64,
    parameter int PC_W    = 64,
    parameter int PC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_vld,
    input  logic [4:0]        flags,
    input  logic [STAT_W-1:0] stat_in,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [PC_W-1:0]   npc_in,
    output logic [STAT_W-1:0] stat_out,
    output logic [PC_W-1:0]   pc_out,
    output logic [PC_W-1:0]   npc_out,
    output logic              upd_vld,
    output logic              trap_req
);
    rec_state_e state_q, state_d;

    logic              take_trap;
    flag_t             trap_flag;
    logic [STAT_W-1:0] stat_nxt;
    logic [PC_W-1:0]   pc_nxt, npc_nxt;

    fpx_trap_eval u_eval (
        .flags     (flags),
        .enables   (stat_in[ENA_LSB +: FLAG_W]),
        .take_trap (take_trap),
        .trap_flag (trap_flag)
    );

    fpx_status_merge #(.STAT_W(STAT_W)) u_merge (
        .stat      (stat_in),
        .flags     (flags),
        .trap_flag (trap_flag),
        .take_trap (take_trap),
        .stat_nxt  (stat_nxt)
    );

    fpx_pc_step #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_pc (
        .pc        (pc_in),
        .npc       (npc_in),
        .take_trap (take_trap),
        .pc_nxt    (pc_nxt),
        .npc_nxt   (npc_nxt)
    );

    // next-state: every strobe records its own outcome
    always_comb begin
        if (!flag_vld)      state_d = S_IDLE;
        else if (take_trap) state_d = S_TRAP;
        else                state_d = S_RETIRE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // data registers load only on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_out <= '0;
            pc_out   <= '0;
            npc_out  <= '0;
        end else if (flag_vld) begin
            stat_out <= stat_nxt;
            pc_out   <= pc_nxt;
            npc_out  <= npc_nxt;
        end
    end

    // output decode from state
    always_comb begin
        unique case (state_q)
            S_IDLE:   begin upd_vld = 1'b0; trap_req = 1'b0; end
            S_RETIRE: begin upd_vld = 1'b1; trap_req = 1'b0; end
            S_TRAP:   begin upd_vld = 1'b1; trap_req = 1'b1; end
            default:  begin upd_vld = 1'b0; trap_req = 1'b0; end
        endcase
    end
endmodule

// File: rtl/fpx_status_recorder_chk.sv
module fpx_status_recorder_chk #(
    parameter int STAT_W  = 64,
    parameter int PC_W    = 64,
    parameter int PC_STEP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flag_vld,
    input logic [4:0]        flags,
    input logic [STAT_W-1:0] stat_in,
    input logic [PC_W-1:0]   pc_in,
    input logic [PC_W-1:0]   npc_in,
    input logic [STAT_W-1:0] stat_out,
    input logic [PC_W-1:0]   pc_out,
    input logic [PC_W-1:0]   npc_out,
    input logic              upd_vld,
    input logic              trap_req
);
    a_r2_trap_decision: assert property (@(posedge clk) disable iff (!rst_n)
        flag_vld |=> (trap_req == $past(|(flags & stat_in[27:23]))));

    a_r3_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ($countones(stat_out[4:0]) == 1));

    a_r5_acc_kept_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (stat_out[9:5] == $past(stat_in[9:5])));

    a_r6_trap_type: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (stat_out[16:14] == 3'd1));

    a_r7_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (pc_out == $past(pc_in) && npc_out == $past(npc_in)));

    a_r8_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_vld && !trap_req) |->
            (pc_out == $past(npc_in) && npc_out == $past(npc_in) + PC_W'(PC_STEP)));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_vld |=> (!upd_vld && !trap_req && $stable(stat_out)));

    a_r10_trap_implies_upd: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> upd_vld);
endmodule

bind fpx_status_recorder fpx_status_recorder_chk #(
    .STAT_W (STAT_W),
    .PC_W   (PC_W),
    .PC_STEP(PC_STEP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_vld (flag_vld),
    .flags    (flags),
    .stat_in  (stat_in),
    .pc_in    (pc_in),
    .npc_in   (npc_in),
    .stat_out (stat_out),
    .pc_out   (pc_out),
    .npc_out  (npc_out),
    .upd_vld  (upd_vld),
    .trap_req (trap_req)
);

// File: tb/fpx_status_recorder_tb.sv
module fpx_status_recorder_tb;
    localparam int SW = 64;
    localparam int PW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flag_vld = 1'b0;
    logic [4:0]    flags = '0;
    logic [SW-1:0] stat_in = '0;
    logic [PW-1:0] pc_in = '0;
    logic [PW-1:0] npc_in = '0;
    logic [SW-1:0] stat_out;
    logic [PW-1:0] pc_out, npc_out;
    logic          upd_vld, trap_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    fpx_status_recorder u_dut (
        .clk(clk), .rst_n(rst_n), .flag_vld(flag_vld), .flags(flags),
        .stat_in(stat_in), .pc_in(pc_in), .npc_in(npc_in),
        .stat_out(stat_out), .pc_out(pc_out), .npc_out(npc_out),
        .upd_vld(upd_vld), .trap_req(trap_req)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit ex_trap(input logic [4:0] f, input logic [SW-1:0] s);
        return |(f & s[27:23]);
    endfunction

    function automatic logic [4:0] ex_pick(input logic [4:0] m);
        if (m[4]) return 5'b10000;
        if (m[3]) return 5'b01000;
        if (m[2]) return 5'b00100;
        if (m[1]) return 5'b00010;
        if (m[0]) return 5'b00001;
        return 5'b0;
    endfunction

    function automatic logic [SW-1:0] ex_stat(input logic [4:0] f, input logic [SW-1:0] s);
        logic [SW-1:0] r = s;
        if (ex_trap(f, s)) begin
            r[4:0]   = ex_pick(f & s[27:23]);
            r[16:14] = 3'd1;
        end else begin
            r[4:0] = f;
            r[9:5] = s[9:5] | f;
        end
        return r;
    endfunction

    // drive one operation at a negedge, check at the next negedge
    task automatic op(input logic [4:0] f, input logic [SW-1:0] s,
                      input logic [PW-1:0] pc, input logic [PW-1:0] npc);
        logic          t;
        logic [SW-1:0] es;
        logic [SW-1:0] keep;
        t  = ex_trap(f, s);
        es = ex_stat(f, s);
        flag_vld = 1'b1; flags = f; stat_in = s; pc_in = pc; npc_in = npc;
        @(negedge clk);
        flag_vld = 1'b0;
        chk(upd_vld == 1'b1, "R10 upd_vld", 64'(upd_vld), 64'd1);
        chk(trap_req == t, "R2 trap_req", 64'(trap_req), 64'(t));
        chk(stat_out[4:0] == es[4:0], t ? "R3 cur field trap" : "R4 cur field",
            64'(stat_out[4:0]), 64'(es[4:0]));
        chk(stat_out[9:5] == es[9:5], "R5 accrued", 64'(stat_out[9:5]), 64'(es[9:5]));
        chk(stat_out[16:14] == es[16:14], "R6 trap type", 64'(stat_out[16:14]), 64'(es[16:14]));
        keep = ~(64'h1f | 64'h3e0 | 64'h1c000);
        chk((stat_out & keep) == (s & keep), "R11 other bits", stat_out & keep, s & keep);
        if (t) begin
            chk(pc_out == pc && npc_out == npc, "R7 pc hold", pc_out, pc);
        end else begin
            chk(pc_out == npc, "R8 pc", pc_out, npc);
            chk(npc_out == npc + 64'd4, "R8 npc", npc_out, npc + 64'd4);
            if (f == 5'd0)
                chk(stat_out[4:0] == 5'd0 && trap_req == 1'b0, "R9 zero flags",
                    64'(stat_out[4:0]), 64'd0);
        end
    endtask

    task automatic idle_chk();
        logic [SW-1:0] s0;
        logic [PW-1:0] p0;
        s0 = stat_out; p0 = pc_out;
        flags = 5'h1f; stat_in = '1;
        @(negedge clk);
        chk(upd_vld == 1'b0 && trap_req == 1'b0, "R10 idle quiet",
            64'({upd_vld, trap_req}), 64'd0);
        chk(stat_out == s0 && pc_out == p0, "R10 idle hold", stat_out, s0);
    endtask

    function automatic logic [63:0] r64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(upd_vld == 1'b0 && trap_req == 1'b0, "R1 reset flags",
            64'({upd_vld, trap_req}), 64'd0);
        chk(stat_out == '0 && pc_out == '0 && npc_out == '0, "R1 reset data", stat_out, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(upd_vld == 1'b0 && stat_out == '0, "R1 after release", stat_out, 64'd0);

        // R3: all flags enabled, invalid wins
        op(5'h1f, 64'h0f80_0000 | 64'h3e0, 64'h100, 64'h104);
        // R3: overflow masked off, underflow wins over divide-by-zero
        op(5'b01110, 64'(5'b00110) << 23, 64'h200, 64'h204);
        // R3: only inexact enabled
        op(5'b10101, 64'(5'b00001) << 23, 64'h300, 64'h304);
        // R4/R5: flags raised, none enabled
        op(5'b11011, 64'hffff_ffff_f07f_c000, 64'h400, 64'h404);
        // R9: zero flags with stale current field
        op(5'd0, 64'hffff_ffff_ffff_ffff, 64'h500, 64'h504);
        // R8: next-PC wraps
        op(5'b00001, 64'h0, 64'hffff_ffff_ffff_fff8, 64'hffff_ffff_ffff_fffc);
        idle_chk();
        // back-to-back trap then retire
        op(5'b01000, 64'(5'b01000) << 23, 64'h600, 64'h604);
        op(5'b01000, 64'h0, 64'h604, 64'h608);
        idle_chk();

        for (int i = 0; i < 400; i++) begin
            logic [SW-1:0] s;
            s = r64();
            if (($urandom % 4) == 0) s[27:23] = 5'd0;
            op(5'($urandom), s, r64(), r64());
            if (($urandom % 8) == 0) idle_chk();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule